// File: doc/BRIEF.md
# Interleaved Configuration Image Section Finder

The block sits on a byte stream that carries several configuration images woven together in fixed-size chunks. Each image gets one chunk in turn. An image selector picks which image to follow. Bytes that belong to the other images are taken off the stream and dropped. From the bytes it keeps, the block first confirms that the image opens with a fixed 13-byte signature. It then walks a chain of tagged sections until it reaches the section letter that was requested.

A caller issues a request with a section letter and a forward flag, then waits for `busy` to fall. `found` together with `sect_len` reports a hit. `error` reports a failure of any kind. When the forward flag is set, the content bytes of the matched section come out on `out_data`. When it is clear, those bytes are consumed without being forwarded. A second request picks up the walk just after the content of the previous hit. A restart strobe rewinds everything to the first byte of the stream.

Top module: `bitsect_finder`

## Requirements
- R1: With `img_sel` = s (numbered from 1), a stream byte at index p (counted from the last restart) is used only when floor(p / CHUNK_BYTES) mod N_IMG equals s-1. Every other accepted byte is dropped.
- R2: The first 13 kept bytes must read 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. On any difference, the request ends with `error`=1 once all 13 bytes have been taken. Every later request then ends at once with `error`=1 and consumes nothing, until a restart.
- R3: After the signature, each section is one tag byte followed by a big-endian length and then that many content bytes. The length takes 2 bytes for tags 0x61..0x64 ('a'..'d') and 4 bytes for tag 0x65 ('e').
- R4: A tag byte outside 0x61..0x65 ends the request with `error`=1.
- R5: A length above SHORT_MAX (255) on any tag other than 'e' ends the request with `error`=1. Tag 'e' is exempt from this limit.
- R6: Each request counts the header bytes it takes, including tag, length and skipped content. Once HDR_LIMIT (100) have been taken without a match, no further tag or skip byte is accepted and the request ends with `error`=1.
- R7: The content of a section whose tag differs from `req_tag` is skipped. On a match, `found`=1 and `sect_len` carries the length.
- R8: `found` and `error` are never both 1. Both are cleared when a request is accepted and hold their values while the block is idle.
- R9: After a match with `req_fwd`=1, each content byte appears on `out_data` with `out_valid`=1 one cycle after it is accepted, in stream order. With `req_fwd`=0 the content is consumed and `out_valid` stays 0.
- R10: A `restart` pulse clears the byte count, the signature state, `busy`, `found` and `error`. The next request starts from stream byte 0.
- R11: `in_ready` is 0 whenever the block is idle, so no byte is taken between requests.
- R12: A request made after a hit continues the walk with the first byte after that hit's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Rewinds the stream count and parser |
| img_sel | input | SEL_W | Selected image, numbered from 1; hold steady between restarts |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte taken on this edge when valid |
| req_valid | input | 1 | Start a search (taken while idle) |
| req_tag | input | 8 | Section letter searched for |
| req_fwd | input | 1 | Forward matched content bytes |
| busy | output | 1 | Search or content consumption in progress |
| found | output | 1 | Last search matched |
| error | output | 1 | Last search failed |
| sect_len | output | LEN_W | Length of the matched section |
| out_valid | output | 1 | Forwarded content byte valid |
| out_data | output | 8 | Forwarded content byte |

## Verification
Four images are interleaved in 8-byte chunks, and every image letter pair (all four selectors times the tags 'a' to 'e') is searched from a fresh restart. Each image is built to end its walk differently: a hit, an oversize short length, a damaged signature, an exhausted header budget, or an illegal tag. This separates the failure causes from one another and from a wrong skip count. After each search, the stream pointer is compared with the index arithmetic of the chunk rotation, which shows whether foreign bytes were dropped and whether the block stopped on the right byte. Chained requests, an 'e' section longer than 255 bytes, a restart in the middle of a search and forwarded content are each compared byte by byte with a reference walk of the image arrays.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_SIG,
    W_TAG,
    W_LEN,
    W_SKIP,
    W_BODY
  } walk_t;

  localparam int SIG_BYTES = 13;
  localparam logic [7:0] TAG_FIRST = 8'h61;
  localparam logic [7:0] TAG_LAST  = 8'h65;
  localparam logic [7:0] TAG_WIDE  = 8'h65;

  function automatic logic [7:0] sig_byte(input logic [3:0] i);
    logic [7:0] b;
    case (i)
      4'd1:                    b = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8:  b = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9:  b = 8'hF0;
      4'd12:                   b = 8'h01;
      default:                 b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bsf_chunk_tracker.sv
module bsf_chunk_tracker #(
  parameter int N_IMG       = 2,
  parameter int CHUNK_BYTES = 288,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [SEL_W-1:0] img_sel,
  output logic             hit
);
  localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam int IMG_W = (N_IMG > 1) ? $clog2(N_IMG) : 1;

  logic [POS_W-1:0] pos;
  logic [IMG_W-1:0] cur;
  logic             wrap;

  assign wrap = (pos == POS_W'(CHUNK_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos <= '0;
    end else if (step) begin
      pos <= wrap ? '0 : pos + 1'b1;
    end
  end

  generate
    if (N_IMG > 1) begin : g_rot
      always_ff @(posedge clk) begin
        if (rst || restart) begin
          cur <= '0;
        end else if (step && wrap) begin
          cur <= (cur == IMG_W'(N_IMG - 1)) ? '0 : cur + 1'b1;
        end
      end
    end else begin : g_single
      assign cur = '0;
    end
  endgenerate

  assign hit = ({{(32-IMG_W){1'b0}}, cur} + 32'd1) == {{(32-SEL_W){1'b0}}, img_sel};

endmodule

// File: rtl/bsf_sig_match.sv
module bsf_sig_match
  import bsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       step,
  input  logic [7:0] data,
  output logic       last,
  output logic       fail
);
  logic [3:0] idx;
  logic       mism;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx  <= '0;
      mism <= 1'b0;
    end else if (step && !last) begin
      idx  <= idx + 1'b1;
      mism <= fail;
    end
  end

  assign last = (idx == 4'(SIG_BYTES - 1));
  assign fail = mism | (data != sig_byte(idx));

endmodule

// File: rtl/bsf_walker.sv
module bsf_walker
  import bsf_pkg::*;
#(
  parameter int HDR_LIMIT = 100,
  parameter int SHORT_MAX = 255,
  parameter int LEN_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             req_valid,
  input  logic [7:0]       req_tag,
  input  logic             req_fwd,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic             sig_last,
  input  logic             sig_fail,
  output logic             sig_step,
  output logic             accept,
  output logic             busy,
  output logic             found,
  output logic             error,
  output logic [LEN_W-1:0] sect_len,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  localparam int CW = $clog2(HDR_LIMIT + 8);

  walk_t            st;
  logic [7:0]       tag_q;
  logic [7:0]       want_q;
  logic             fwd_q;
  logic [CW-1:0]    hcnt;
  logic [LEN_W-1:0] acc;
  logic [LEN_W-1:0] rem;
  logic [1:0]       lcnt;
  logic             sig_ok;
  logic             sig_bad;
  logic             spent;
  logic [LEN_W-1:0] acc_n;

  assign spent    = (hcnt >= CW'(HDR_LIMIT));
  assign busy     = (st != W_IDLE);
  assign accept   = busy && !restart && !(((st == W_TAG) || (st == W_SKIP)) && spent);
  assign sig_step = take && (st == W_SIG);
  assign acc_n    = {acc[LEN_W-9:0], data};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      st        <= W_IDLE;
      tag_q     <= '0;
      want_q    <= '0;
      fwd_q     <= 1'b0;
      hcnt      <= '0;
      acc       <= '0;
      rem       <= '0;
      lcnt      <= '0;
      sig_ok    <= 1'b0;
      sig_bad   <= 1'b0;
      found     <= 1'b0;
      error     <= 1'b0;
      sect_len  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        W_IDLE: begin
          if (req_valid) begin
            found  <= 1'b0;
            error  <= 1'b0;
            want_q <= req_tag;
            fwd_q  <= req_fwd;
            hcnt   <= '0;
            if (sig_bad)     error <= 1'b1;
            else if (sig_ok) st    <= W_TAG;
            else             st    <= W_SIG;
          end
        end
        W_SIG: begin
          if (take && sig_last) begin
            if (sig_fail) begin
              sig_bad <= 1'b1;
              error   <= 1'b1;
              st      <= W_IDLE;
            end else begin
              sig_ok <= 1'b1;
              st     <= W_TAG;
            end
          end
        end
        W_TAG: begin
          if (spent) begin
            error <= 1'b1;
            st    <= W_IDLE;
          end else if (take) begin
            hcnt  <= hcnt + 1'b1;
            tag_q <= data;
            if ((data < TAG_FIRST) || (data > TAG_LAST)) begin
              error <= 1'b1;
              st    <= W_IDLE;
            end else begin
              lcnt <= (data == TAG_WIDE) ? 2'd3 : 2'd1;
              acc  <= '0;
              st   <= W_LEN;
            end
          end
        end
        W_LEN: begin
          if (take) begin
            hcnt <= hcnt + 1'b1;
            acc  <= acc_n;
            lcnt <= lcnt - 1'b1;
            if (lcnt == 2'd0) begin
              rem <= acc_n;
              if ((tag_q != TAG_WIDE) && (acc_n > LEN_W'(SHORT_MAX))) begin
                error <= 1'b1;
                st    <= W_IDLE;
              end else if (tag_q == want_q) begin
                found    <= 1'b1;
                sect_len <= acc_n;
                st       <= (acc_n == '0) ? W_IDLE : W_BODY;
              end else begin
                st <= (acc_n == '0) ? W_TAG : W_SKIP;
              end
            end
          end
        end
        W_SKIP: begin
          if (spent) begin
            error <= 1'b1;
            st    <= W_IDLE;
          end else if (take) begin
            hcnt <= hcnt + 1'b1;
            rem  <= rem - 1'b1;
            if (rem == LEN_W'(1)) st <= W_TAG;
          end
        end
        W_BODY: begin
          if (take) begin
            rem       <= rem - 1'b1;
            out_valid <= fwd_q;
            out_data  <= data;
            if (rem == LEN_W'(1)) st <= W_IDLE;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitsect_finder.sv
module bitsect_finder #(
  parameter int N_IMG       = 2,
  parameter int CHUNK_BYTES = 288,
  parameter int HDR_LIMIT   = 100,
  parameter int SHORT_MAX   = 255,
  parameter int LEN_W       = 32,
  parameter int SEL_W       = $clog2(N_IMG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] img_sel,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             req_valid,
  input  logic [7:0]       req_tag,
  input  logic             req_fwd,
  output logic             busy,
  output logic             found,
  output logic             error,
  output logic [LEN_W-1:0] sect_len,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  logic step;
  logic hit;
  logic take;
  logic sig_step;
  logic sig_last;
  logic sig_fail;

  assign step = in_valid && in_ready;
  assign take = step && hit;

  bsf_chunk_tracker #(
    .N_IMG      (N_IMG),
    .CHUNK_BYTES(CHUNK_BYTES),
    .SEL_W      (SEL_W)
  ) i_track (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .step   (step),
    .img_sel(img_sel),
    .hit    (hit)
  );

  bsf_sig_match i_sig (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .step   (sig_step),
    .data   (in_data),
    .last   (sig_last),
    .fail   (sig_fail)
  );

  bsf_walker #(
    .HDR_LIMIT(HDR_LIMIT),
    .SHORT_MAX(SHORT_MAX),
    .LEN_W    (LEN_W)
  ) i_walk (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .req_valid(req_valid),
    .req_tag  (req_tag),
    .req_fwd  (req_fwd),
    .take     (take),
    .data     (in_data),
    .sig_last (sig_last),
    .sig_fail (sig_fail),
    .sig_step (sig_step),
    .accept   (in_ready),
    .busy     (busy),
    .found    (found),
    .error    (error),
    .sect_len (sect_len),
    .out_valid(out_valid),
    .out_data (out_data)
  );

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             in_ready,
  input logic             req_valid,
  input logic             busy,
  input logic             found,
  input logic             error,
  input logic [LEN_W-1:0] sect_len,
  input logic             out_valid,
  input logic [7:0]       out_data
);

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(found && error));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid && !restart) |=> ($stable(found) && $stable(error) && $stable(sect_len)));

  assert_req_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !restart) |=> !found);

  assert_idle_stall_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready);

  assert_fwd_data_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid && in_ready) && (out_data == $past(in_data))));

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!busy && !found && !error));

endmodule

bind bitsect_finder bsf_checker #(.LEN_W(LEN_W)) i_bsf_checker (
  .clk      (clk),
  .rst      (rst),
  .restart  (restart),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .req_valid(req_valid),
  .busy     (busy),
  .found    (found),
  .error    (error),
  .sect_len (sect_len),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_bitsect_finder.sv
module test_bitsect_finder;
  localparam int N    = 4;
  localparam int CH   = 8;
  localparam int LIM  = 100;
  localparam int IMAX = 512;
  localparam int SLEN = N * IMAX;

  logic        clk = 1'b0;
  logic        rst, restart, in_valid, req_valid, req_fwd;
  logic [2:0]  img_sel;
  logic [7:0]  in_data, req_tag, out_data;
  logic        in_ready, busy, found, error, out_valid;
  logic [31:0] sect_len;

  logic [7:0] img  [N][IMAX];
  logic [7:0] strm [SLEN];
  int wpos [N];
  int ptr, total, bad;
  bit pend;
  int mk, m_pos;
  bit m_sigok, m_sigbad;
  bit fw_on;
  int fw_k, fw_pos, fw_cnt;

  always #4 clk = ~clk;

  assign in_data = (ptr < SLEN) ? strm[ptr] : 8'h00;

  bitsect_finder #(.N_IMG(N), .CHUNK_BYTES(CH), .HDR_LIMIT(LIM), .SHORT_MAX(255), .LEN_W(32)) i_bitsect_finder (
    .clk(clk), .rst(rst), .restart(restart), .img_sel(img_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_valid(req_valid), .req_tag(req_tag), .req_fwd(req_fwd),
    .busy(busy), .found(found), .error(error), .sect_len(sect_len),
    .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input string rq, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] sigb(input int i);
    if (i == 1) return 8'h09;
    if (i == 12) return 8'h01;
    if (i >= 2 && i <= 9) return (i % 2 == 0) ? 8'h0F : 8'hF0;
    return 8'h00;
  endfunction

  function automatic int sidx(input int k, input int j);
    return (j / CH) * CH * N + k * CH + (j % CH);
  endfunction

  task automatic put(input int k, input logic [7:0] b);
    img[k][wpos[k]] = b;
    wpos[k]++;
  endtask

  task automatic put_sig(input int k, input bit damage);
    for (int i = 0; i < 13; i++) put(k, (damage && i == 7) ? 8'hF1 : sigb(i));
  endtask

  task automatic put_sec(input int k, input logic [7:0] t, input int len);
    put(k, t);
    if (t == 8'h65) begin
      put(k, len[31:24]);
      put(k, len[23:16]);
    end
    put(k, len[15:8]);
    put(k, len[7:0]);
    for (int i = 0; i < len; i++) put(k, 8'((k * 37 + wpos[k] * 5 + 3)));
  endtask

  // reference walk over the image arrays
  task automatic model(input logic [7:0] want, output bit f, output bit e, output int len, output int cst);
    int cnt;
    logic [7:0] t;
    int nl;
    longint ln;
    bit mm;
    f = 0; e = 0; len = 0; cst = 0;
    if (m_sigbad) begin e = 1; return; end
    if (!m_sigok) begin
      mm = 0;
      for (int i = 0; i < 13; i++) if (img[mk][m_pos + i] != sigb(i)) mm = 1;
      m_pos += 13;
      if (mm) begin m_sigbad = 1; e = 1; return; end
      m_sigok = 1;
    end
    cnt = 0;
    while (1) begin
      if (cnt >= LIM) begin e = 1; return; end
      t = img[mk][m_pos]; m_pos++; cnt++;
      if (t < 8'h61 || t > 8'h65) begin e = 1; return; end
      nl = (t == 8'h65) ? 4 : 2;
      ln = 0;
      for (int i = 0; i < nl; i++) begin ln = (ln << 8) | img[mk][m_pos]; m_pos++; cnt++; end
      if (t != 8'h65 && ln > 255) begin e = 1; return; end
      if (t == want) begin f = 1; len = int'(ln); cst = m_pos; m_pos += len; return; end
      for (longint i = 0; i < ln; i++) begin
        if (cnt >= LIM) begin e = 1; return; end
        m_pos++; cnt++;
      end
    end
  endtask

  task automatic cyc();
    pend = in_ready;
    @(negedge clk);
    if (pend) ptr++;
    if (out_valid) begin
      if (!fw_on) chk("R9 forward while not enabled", 1, 0);
      else chk("R9 forwarded byte", out_data, img[fw_k][fw_pos]);
      fw_pos++;
      fw_cnt++;
    end
  endtask

  task automatic do_restart(input int sel);
    img_sel = 3'(sel);
    restart = 1'b1;
    fw_on = 0;
    @(negedge clk);
    restart = 1'b0;
    ptr = 0; pend = 0;
    mk = sel - 1; m_pos = 0; m_sigok = 0; m_sigbad = 0;
    chk("R10 busy after restart", busy, 0);
    chk("R10 found after restart", found, 0);
    chk("R10 error after restart", error, 0);
  endtask

  task automatic search(input logic [7:0] tag, input bit fwd, input string rq);
    bit ef, ee;
    int elen, cst, p0, n, pos0, ps;
    logic f0, e0;
    pos0 = m_pos;
    model(tag, ef, ee, elen, cst);
    fw_on = fwd && ef; fw_k = mk; fw_pos = cst; fw_cnt = 0;
    req_valid = 1'b1; req_tag = tag; req_fwd = fwd;
    cyc();
    req_valid = 1'b0;
    n = 0;
    while (busy && n < 5000) begin cyc(); n++; end
    chk({rq, " found R7"}, found, ef);
    chk({rq, " error"}, error, ee);
    if (ef) chk({rq, " length R3"}, sect_len, elen);
    if (fwd && ef) chk({rq, " forward count R9"}, fw_cnt, elen);
    if (m_pos != pos0) chk({rq, " stream position R1"}, ptr, sidx(mk, m_pos - 1) + 1);
    else chk({rq, " no bytes taken R2"}, ptr, ptr);
    p0 = ptr; f0 = found; e0 = error;
    fw_on = 0;
    repeat (3) cyc();
    chk({rq, " idle takes nothing R11"}, ptr, p0);
    ps = (found == f0 && error == e0) ? 1 : 0;
    chk({rq, " results held R8"}, ps, 1);
    chk({rq, " exclusive R8"}, found && error, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    for (int k = 0; k < N; k++) begin
      wpos[k] = 0;
      for (int j = 0; j < IMAX; j++) img[k][j] = 8'h00;
    end
    // image 1: valid chain ending in an oversize short length
    put_sig(0, 0);
    put_sec(0, 8'h61, 3); put_sec(0, 8'h62, 2); put_sec(0, 8'h63, 0);
    put_sec(0, 8'h64, 5); put_sec(0, 8'h65, 6);
    put(0, 8'h62); put(0, 8'h01); put(0, 8'h23);
    // image 2: damaged signature
    put_sig(1, 1); put_sec(1, 8'h61, 1);
    // image 3: header budget runs out
    put_sig(2, 0); put_sec(2, 8'h61, 60); put_sec(2, 8'h62, 60); put_sec(2, 8'h64, 1);
    // image 4: long wide section, then an illegal tag
    put_sig(3, 0); put_sec(3, 8'h61, 1); put_sec(3, 8'h65, 261);
    put(3, 8'h66); put(3, 8'h00); put(3, 8'h00);
    for (int k = 0; k < N; k++)
      for (int j = 0; j < IMAX; j++) strm[sidx(k, j)] = img[k][j];

    rst = 1'b1; restart = 1'b0; req_valid = 1'b0; req_tag = 8'h00; req_fwd = 1'b0;
    in_valid = 1'b1; img_sel = 3'd1; ptr = 0; pend = 0; fw_on = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 reset found", found, 0);
    chk("R8 reset error", error, 0);
    chk("R11 reset ready", in_ready, 0);
    chk("R9 reset out_valid", out_valid, 0);

    do_restart(1);
    search(8'h64, 1, "R7 skip to d");
    search(8'h65, 1, "R12 chained wide tag");
    search(8'h61, 0, "R5 oversize short length");

    do_restart(2);
    search(8'h61, 0, "R2 bad signature");
    search(8'h61, 0, "R2 sticky bad signature");

    do_restart(3);
    search(8'h64, 0, "R6 header budget");

    do_restart(4);
    search(8'h65, 1, "R5 wide tag exempt");
    search(8'h61, 0, "R4 illegal tag");

    do_restart(3);
    req_valid = 1'b1; req_tag = 8'h64; req_fwd = 1'b0;
    cyc();
    req_valid = 1'b0;
    repeat (20) cyc();
    do_restart(3);
    search(8'h62, 1, "R10 fresh walk after mid restart");

    for (int s = 1; s <= N; s++)
      for (int t = 0; t < 5; t++) begin
        do_restart(s);
        search(8'(8'h61 + t), t[0], "R1 sweep");
      end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule